// File: doc/BRIEF.md
# Warp Issue Scheduler With Three Execution Datapaths

This block is the issue stage of one SIMT processing partition. It watches up to twelve resident warps. Each warp offers one pending instruction, tagged with an operation class and a ready flag. In every clock the block picks at most one warp and sends its instruction to one of three execution datapaths. Each datapath has its own occupancy time. A datapath that is still occupied takes no new work, so long matrix operations run alongside short FP32 and INT32 work while issue stays at one instruction per clock.

Each datapath has an occupancy down-counter. When an instruction issues to a path, that path's counter is loaded with the instruction's length minus one. The path can accept a new instruction again once its counter has reached zero. Warps are picked round-robin: the search starts just after the warp that issued last. A warp is eligible only if it is ready, its class code is valid, and at least one datapath legal for that class is free.

The block also keeps a cycle counter for each datapath, counting the cycles in which that path was occupied, and a total cycle counter. Comparing the two gives the utilisation of each path.

Top module: `warp_issue_sched`

## Requirements
- R1: In any cycle at most one instruction issues. When `issue_valid` is high, exactly one datapath is the target, named by `issue_path` as 0, 1 or 2.
- R2: Class codes and their legal paths:
  - FP32=0 may go to path 0 or path 1.
  - INT32=1 goes to path 0 only.
  - FP16=2, MMA_SMALL=3, MMA_LARGE=4 and MMA_SPARSE=5 go to path 2 only.
  - Codes 6 and 7 are never issued.
- R3: Occupancy lengths are 2 cycles for FP32 and INT32, 1 cycle for FP16, 8 cycles for MMA_SMALL, and 16 cycles for MMA_LARGE and MMA_SPARSE. A path issued at cycle t holds `path_busy` high for the remaining length−1 cycles after t. It accepts again at cycle t+length.
- R4: No instruction issues to a path whose `path_busy` is high. An instruction whose legal paths are all busy waits; another eligible warp may issue in its place.
- R5: An FP32 instruction goes to path 1 whenever path 1 is free, and to path 0 otherwise.
- R6: A warp whose `warp_ready` bit is low is never issued.
- R7: Warps are picked round-robin, starting at the index after the last issued warp and wrapping after warp 11. If any warp is eligible, one issues. If none is, `issue_valid` stays low.
- R8: `busy_cycles[32*p +: 32]` counts the cycles in which path p was issued to or busy.
- R9: `total_cycles` counts the clock edges since reset was released.
- R10: Synchronous active-high `rst` clears all occupancy, both counters and the round-robin pointer. After reset the lowest-numbered eligible warp issues first.
- R11: Two ready FP32 warps issue on every cycle, alternating between paths 1 and 0, so both paths reach full occupancy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| warp_ready | input | 12 | Per-warp ready flag; bit w belongs to warp w |
| warp_class | input | 36 | Per-warp class code; bits [3w+2:3w] belong to warp w |
| issue_valid | output | 1 | Issue strobe for this cycle |
| issue_warp | output | 4 | Index of the issued warp |
| issue_path | output | 2 | Target datapath, 0 to 2 |
| path_busy | output | 3 | Per-path residual occupancy from earlier issues |
| busy_cycles | output | 96 | Three 32-bit occupied-cycle counters, path p at [32p+31:32p] |
| total_cycles | output | 32 | Cycles since reset release |

## Verification
The properties assume that the class field of each warp is stable within a cycle. They also assume that `warp_ready` and `warp_class` change only between clock edges, since the issue decision is combinational from those inputs and the path state. The bench drives every input on the falling edge and samples the outputs one time unit later. This keeps each decision in a single cycle. The stimulus includes the invalid class codes 6 and 7, and instructions held back because their path is busy. These check that the routing and occupancy properties hold without any help from the inputs.

// File: rtl/wsched_pkg.sv
package wsched_pkg;
  localparam int NUM_PATHS = 3;
  localparam int PATH_W    = 2;
  localparam int OCC_W     = 5;
  localparam int CLS_W     = 3;

  typedef enum logic [CLS_W-1:0] {
    OP_FP32    = 3'd0,
    OP_INT32   = 3'd1,
    OP_FP16    = 3'd2,
    OP_MMA_S   = 3'd3,
    OP_MMA_L   = 3'd4,
    OP_MMA_SP  = 3'd5
  } op_class_e;

  // set of datapaths a class may use; bit p stands for path p
  function automatic logic [NUM_PATHS-1:0] legal_paths(input logic [CLS_W-1:0] cls);
    case (cls)
      OP_FP32:                               legal_paths = 3'b011;
      OP_INT32:                              legal_paths = 3'b001;
      OP_FP16, OP_MMA_S, OP_MMA_L, OP_MMA_SP: legal_paths = 3'b100;
      default:                               legal_paths = 3'b000;
    endcase
  endfunction

  // cycles a datapath stays occupied by one warp instruction
  function automatic logic [OCC_W-1:0] occ_cycles(input logic [CLS_W-1:0] cls);
    case (cls)
      OP_FP32, OP_INT32:     occ_cycles = OCC_W'(2);
      OP_FP16:               occ_cycles = OCC_W'(1);
      OP_MMA_S:              occ_cycles = OCC_W'(8);
      OP_MMA_L, OP_MMA_SP:   occ_cycles = OCC_W'(16);
      default:               occ_cycles = OCC_W'(1);
    endcase
  endfunction

  // pick the target path; FP32 prefers path 1 to keep path 0 open for INT32
  function automatic logic [PATH_W-1:0] route(input logic [CLS_W-1:0] cls,
                                              input logic [NUM_PATHS-1:0] free);
    if (cls == OP_FP32)       route = free[1] ? PATH_W'(1) : PATH_W'(0);
    else if (cls == OP_INT32) route = PATH_W'(0);
    else                      route = PATH_W'(2);
  endfunction
endpackage

// File: rtl/occ_tracker.sv
module occ_tracker #(
  parameter int OCC_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [OCC_W-1:0] load_len,
  output logic             free,
  output logic             occupied
);
  logic [OCC_W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst)                 remain_q <= '0;
    else if (load)           remain_q <= load_len;
    else if (remain_q != '0) remain_q <= remain_q - OCC_W'(1);
  end

  assign free     = (remain_q == '0);
  assign occupied = load | ~free;
endmodule

// File: rtl/rr_select.sv
module rr_select #(
  parameter  int NUM_WARPS = 12,
  localparam int WID_W     = $clog2(NUM_WARPS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_WARPS-1:0] elig,
  output logic                 found,
  output logic [WID_W-1:0]     pick
);
  logic [WID_W-1:0] last_q;
  int               cand;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    cand  = 0;
    for (int i = 1; i <= NUM_WARPS; i++) begin
      cand = (int'(last_q) + i) % NUM_WARPS;
      if (!found && elig[WID_W'(cand)]) begin
        found = 1'b1;
        pick  = WID_W'(cand);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        last_q <= WID_W'(NUM_WARPS - 1);
    else if (found) last_q <= pick;
  end
endmodule

// File: rtl/busy_stats.sv
module busy_stats #(
  parameter int NUM_PATHS = 3,
  parameter int CNT_W     = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_PATHS-1:0]       occupied,
  output logic [NUM_PATHS*CNT_W-1:0] busy_cycles,
  output logic [CNT_W-1:0]           total_cycles
);
  logic [CNT_W-1:0] total_q;

  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
    logic [CNT_W-1:0] cnt_q;
    always_ff @(posedge clk) begin
      if (rst)              cnt_q <= '0;
      else if (occupied[p]) cnt_q <= cnt_q + CNT_W'(1);
    end
    assign busy_cycles[p*CNT_W +: CNT_W] = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) total_q <= '0;
    else     total_q <= total_q + CNT_W'(1);
  end
  assign total_cycles = total_q;
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
  import wsched_pkg::*;
#(
  parameter  int NUM_WARPS = 12,
  parameter  int CNT_W     = 32,
  localparam int WID_W     = $clog2(NUM_WARPS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_WARPS-1:0]       warp_ready,
  input  logic [CLS_W*NUM_WARPS-1:0] warp_class,
  output logic                       issue_valid,
  output logic [WID_W-1:0]           issue_warp,
  output logic [PATH_W-1:0]          issue_path,
  output logic [NUM_PATHS-1:0]       path_busy,
  output logic [NUM_PATHS*CNT_W-1:0] busy_cycles,
  output logic [CNT_W-1:0]           total_cycles
);
  // named internal events, observed by the bound checker
  logic [NUM_PATHS-1:0] path_free;
  logic [NUM_PATHS-1:0] path_issue;
  logic [NUM_PATHS-1:0] path_occupied;
  logic [NUM_WARPS-1:0] warp_elig;

  logic                 pick_found;
  logic [WID_W-1:0]     pick_idx;
  logic [CLS_W-1:0]     sel_cls;
  logic [PATH_W-1:0]    sel_path;
  logic [OCC_W-1:0]     issue_len;

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_elig
    logic [CLS_W-1:0] cls_w;
    assign cls_w        = warp_class[CLS_W*w +: CLS_W];
    assign warp_elig[w] = warp_ready[w] & (|(legal_paths(cls_w) & path_free));
  end

  rr_select #(.NUM_WARPS(NUM_WARPS)) u_rr (
    .clk   (clk),
    .rst   (rst),
    .elig  (warp_elig),
    .found (pick_found),
    .pick  (pick_idx)
  );

  assign sel_cls   = warp_class[CLS_W*pick_idx +: CLS_W];
  assign sel_path  = route(sel_cls, path_free);
  assign issue_len = occ_cycles(sel_cls) - OCC_W'(1);

  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
    assign path_issue[p] = pick_found && (sel_path == PATH_W'(p));
    occ_tracker #(.OCC_W(OCC_W)) u_occ (
      .clk      (clk),
      .rst      (rst),
      .load     (path_issue[p]),
      .load_len (issue_len),
      .free     (path_free[p]),
      .occupied (path_occupied[p])
    );
  end

  busy_stats #(.NUM_PATHS(NUM_PATHS), .CNT_W(CNT_W)) u_stats (
    .clk          (clk),
    .rst          (rst),
    .occupied     (path_occupied),
    .busy_cycles  (busy_cycles),
    .total_cycles (total_cycles)
  );

  assign issue_valid = pick_found;
  assign issue_warp  = pick_found ? pick_idx : '0;
  assign issue_path  = pick_found ? sel_path : '0;
  assign path_busy   = ~path_free;
endmodule

// File: rtl/sched_checker.sv
module sched_checker
  import wsched_pkg::*;
#(
  parameter  int NUM_WARPS = 12,
  parameter  int CNT_W     = 32,
  localparam int WID_W     = $clog2(NUM_WARPS)
) (
  input logic                       clk,
  input logic                       rst,
  input logic [NUM_WARPS-1:0]       warp_ready,
  input logic [CLS_W*NUM_WARPS-1:0] warp_class,
  input logic [NUM_WARPS-1:0]       warp_elig,
  input logic [NUM_PATHS-1:0]       path_issue,
  input logic                       issue_valid,
  input logic [WID_W-1:0]           issue_warp,
  input logic [PATH_W-1:0]          issue_path,
  input logic [NUM_PATHS-1:0]       path_busy,
  input logic [NUM_PATHS*CNT_W-1:0] busy_cycles,
  input logic [CNT_W-1:0]           total_cycles
);
  logic [CLS_W-1:0]     chk_cls;
  logic [NUM_PATHS-1:0] chk_occ;

  assign chk_cls = warp_class[CLS_W*issue_warp +: CLS_W];

  p_one_target_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(path_issue) && (issue_valid == (path_issue != '0)));

  p_legal_route_r2: assert property (@(posedge clk) disable iff (rst)
    issue_valid |-> ((chk_cls == OP_FP32 && issue_path != 2'd2) ||
                     (chk_cls == OP_INT32 && issue_path == 2'd0) ||
                     ((chk_cls inside {OP_FP16, OP_MMA_S, OP_MMA_L, OP_MMA_SP}) && issue_path == 2'd2)));

  p_hold_p0_r3: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && issue_path == 2'd0) |=> path_busy[0]);

  p_release_p0_r3: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && issue_path == 2'd0) |-> ##2 !path_busy[0]);

  p_release_p1_r3: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && issue_path == 2'd1) |-> ##2 !path_busy[1]);

  p_idle_target_r4: assert property (@(posedge clk) disable iff (rst)
    issue_valid |-> !path_busy[issue_path]);

  p_fp32_pref_r5: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && chk_cls == OP_FP32 && !path_busy[1]) |-> issue_path == 2'd1);

  p_ready_only_r6: assert property (@(posedge clk) disable iff (rst)
    issue_valid |-> warp_ready[issue_warp]);

  p_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (warp_elig == '0) |-> !issue_valid);

  p_conserve_r7: assert property (@(posedge clk) disable iff (rst)
    (warp_elig != '0) |-> issue_valid);

  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_cnt
    assign chk_occ[p] = (issue_valid && issue_path == PATH_W'(p)) || path_busy[p];
    p_busy_count_r8: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> busy_cycles[p*CNT_W +: CNT_W] ==
               $past(busy_cycles[p*CNT_W +: CNT_W]) + CNT_W'($past(chk_occ[p])));
  end

  p_total_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> total_cycles == $past(total_cycles) + CNT_W'(1));

  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> (total_cycles == '0) && (path_busy == '0) && (busy_cycles == '0));
endmodule

bind warp_issue_sched sched_checker #(.NUM_WARPS(NUM_WARPS), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .warp_ready   (warp_ready),
  .warp_class   (warp_class),
  .warp_elig    (warp_elig),
  .path_issue   (path_issue),
  .issue_valid  (issue_valid),
  .issue_warp   (issue_warp),
  .issue_path   (issue_path),
  .path_busy    (path_busy),
  .busy_cycles  (busy_cycles),
  .total_cycles (total_cycles)
);

// File: tb/sim_warp_issue_sched.sv
module sim_warp_issue_sched;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 12;
  localparam int CW = 32;
  localparam int NROWS = 19;

  logic          clk = 1'b0;
  logic          rst;
  logic [NW-1:0] warp_ready;
  logic [3*NW-1:0] warp_class;
  logic          issue_valid;
  logic [3:0]    issue_warp;
  logic [1:0]    issue_path;
  logic [2:0]    path_busy;
  logic [3*CW-1:0] busy_cycles;
  logic [CW-1:0] total_cycles;

  int n_chk = 0;
  int n_bad = 0;
  int edges = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  warp_issue_sched u0 (
    .clk(clk), .rst(rst), .warp_ready(warp_ready), .warp_class(warp_class),
    .issue_valid(issue_valid), .issue_warp(issue_warp), .issue_path(issue_path),
    .path_busy(path_busy), .busy_cycles(busy_cycles), .total_cycles(total_cycles)
  );

  // ready mask, class of warps 0..5, class of warps 6..11, expected strobe/warp/path
  typedef struct packed {
    logic [11:0] rdy;
    logic [2:0]  lo;
    logic [2:0]  hi;
    logic        v;
    logic [3:0]  w;
    logic [1:0]  p;
  } vec_t;

  localparam vec_t TABLE [NROWS] = '{
    '{12'h000, 3'd0, 3'd0, 1'b0, 4'd0,  2'd0},  // nothing ready
    '{12'h001, 3'd0, 3'd0, 1'b1, 4'd0,  2'd1},  // FP32 both free -> path 1
    '{12'h003, 3'd0, 3'd0, 1'b1, 4'd1,  2'd0},
    '{12'h003, 3'd0, 3'd0, 1'b1, 4'd0,  2'd1},
    '{12'h003, 3'd0, 3'd0, 1'b1, 4'd1,  2'd0},
    '{12'h041, 3'd0, 3'd1, 1'b1, 4'd0,  2'd1},  // INT32 blocked, FP32 goes
    '{12'h040, 3'd0, 3'd1, 1'b1, 4'd6,  2'd0},
    '{12'h081, 3'd0, 3'd3, 1'b1, 4'd7,  2'd2},  // 8-cycle matrix op
    '{12'h102, 3'd1, 3'd2, 1'b1, 4'd1,  2'd0},  // FP16 waits, INT32 issues
    '{12'h100, 3'd0, 3'd2, 1'b0, 4'd0,  2'd0},
    '{12'h300, 3'd0, 3'd7, 1'b0, 4'd0,  2'd0},  // invalid code
    '{12'h100, 3'd0, 3'd6, 1'b0, 4'd0,  2'd0},  // invalid code
    '{12'h000, 3'd0, 3'd0, 1'b0, 4'd0,  2'd0},
    '{12'h000, 3'd0, 3'd0, 1'b0, 4'd0,  2'd0},
    '{12'h100, 3'd0, 3'd2, 1'b0, 4'd0,  2'd0},  // last busy cycle of path 2
    '{12'h100, 3'd0, 3'd2, 1'b1, 4'd8,  2'd2},
    '{12'h300, 3'd0, 3'd2, 1'b1, 4'd9,  2'd2},  // FP16 frees at once
    '{12'h300, 3'd0, 3'd2, 1'b1, 4'd8,  2'd2},
    '{12'h408, 3'd7, 3'd0, 1'b1, 4'd10, 2'd1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [3*NW-1:0] mk_cls(input logic [2:0] lo, input logic [2:0] hi);
    logic [3*NW-1:0] r;
    for (int w = 0; w < NW; w++) r[3*w +: 3] = (w < 6) ? lo : hi;
    return r;
  endfunction

  function automatic int bc(input int p);
    return int'(busy_cycles[p*CW +: CW]);
  endfunction

  task automatic tick();
    @(posedge clk);
    edges++;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    warp_ready = '0;
    warp_class = '0;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    edges = 0;
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  // long path-2 occupancy, then counters
  task automatic run_long(input logic [2:0] cls, input int len);
    do_reset();
    warp_ready = 12'h008;
    warp_class[9 +: 3] = cls;
    #1;
    chk(issue_valid && issue_warp == 4'd3 && issue_path == 2'd2, "R2 long issue", int'(issue_path), 2);
    tick();
    warp_ready = 12'h010;
    warp_class[12 +: 3] = 3'd2;
    for (int k = 1; k < len; k++) begin
      #1;
      chk(path_busy[2] == 1'b1, "R3 path 2 held", int'(path_busy[2]), 1);
      chk(issue_valid == 1'b0, "R4 busy path blocks", int'(issue_valid), 0);
      tick();
    end
    #1;
    chk(path_busy[2] == 1'b0, "R3 path 2 released", int'(path_busy[2]), 0);
    chk(issue_valid && issue_warp == 4'd4, "R3 reissue at length", int'(issue_warp), 4);
    tick();
    warp_ready = '0;
    #1;
    chk(bc(2) == len + 1, "R8 path 2 count", bc(2), len + 1);
    chk(bc(0) == 0 && bc(1) == 0, "R8 fp paths idle", bc(0) + bc(1), 0);
    chk(int'(total_cycles) == edges, "R9 total", int'(total_cycles), edges);
  endtask

  initial begin
    rst = 1'b1;
    warp_ready = '0;
    warp_class = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    edges = 0;
    #1;
    chk(issue_valid == 1'b0, "R10 reset strobe", int'(issue_valid), 0);
    chk(path_busy == 3'b000, "R10 reset busy", int'(path_busy), 0);
    chk(total_cycles == '0 && busy_cycles == '0, "R10 reset counters", int'(total_cycles), 0);

    // vector table
    for (int r = 0; r < NROWS; r++) begin
      warp_ready = TABLE[r].rdy;
      warp_class = mk_cls(TABLE[r].lo, TABLE[r].hi);
      #1;
      chk(issue_valid == TABLE[r].v, $sformatf("R7 R6 R2 strobe row %0d", r), int'(issue_valid), int'(TABLE[r].v));
      if (TABLE[r].v) begin
        chk(issue_warp == TABLE[r].w, $sformatf("R7 warp row %0d", r), int'(issue_warp), int'(TABLE[r].w));
        chk(issue_path == TABLE[r].p, $sformatf("R5 R4 R1 path row %0d", r), int'(issue_path), int'(TABLE[r].p));
      end
      tick();
    end

    // occupancy lengths of the three matrix classes
    run_long(3'd3, 8);
    run_long(3'd4, 16);
    run_long(3'd5, 16);

    // alternating FP32 keeps both paths full
    do_reset();
    warp_ready = 12'h003;
    warp_class = mk_cls(3'd0, 3'd0);
    for (int i = 0; i < 8; i++) begin
      #1;
      chk(issue_valid == 1'b1, "R11 issue every cycle", int'(issue_valid), 1);
      chk(issue_path == ((i % 2 == 0) ? 2'd1 : 2'd0), "R11 R5 alternation", int'(issue_path), (i % 2 == 0) ? 1 : 0);
      chk(int'(issue_warp) == i % 2, "R7 alternation warp", int'(issue_warp), i % 2);
      tick();
    end
    warp_ready = '0;
    tick();
    #1;
    chk(bc(0) == 8 && bc(1) == 8, "R11 R8 full occupancy", bc(0) + bc(1), 16);
    chk(int'(total_cycles) == 9, "R9 total after alternation", int'(total_cycles), 9);

    // pointer restarts at warp 0 after reset
    do_reset();
    warp_ready = 12'h024;
    warp_class = mk_cls(3'd0, 3'd0);
    #1;
    chk(issue_valid && issue_warp == 4'd2, "R10 lowest first", int'(issue_warp), 2);

    // reset in the middle of a long occupancy
    do_reset();
    warp_ready = 12'h008;
    warp_class[9 +: 3] = 3'd4;
    tick();
    warp_ready = '0;
    tick();
    tick();
    rst = 1'b1;
    tick();
    rst = 1'b0;
    warp_ready = 12'h010;
    warp_class[12 +: 3] = 3'd2;
    #1;
    chk(path_busy == 3'b000, "R10 occupancy cleared", int'(path_busy), 0);
    chk(issue_valid && issue_path == 2'd2, "R10 path 2 open", int'(issue_path), 2);
    chk(total_cycles == '0 && busy_cycles == '0, "R10 counters cleared", int'(total_cycles), 0);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule